// File: doc/BRIEF.md
# Interrupt Vector Selection Controller

This block sits next to an 8-bit microprogrammed processor core and supplies the 16-bit service-routine address that the core loads into its program counter when it enters an exception sequence. Each cycle it looks at four kinds of request: the reset request, the non-maskable request, the maskable request, and a software break. It finds a software break by checking whether the instruction register holds the zero opcode. It picks one winner by fixed priority and forms the matching vector.

The core raises a one-cycle vector-request strobe while it pushes the return state. On the clock edge where that strobe is high and some source is accepted, the block captures the selected vector and a 2-bit source code. Both outputs then hold until the next accepted strobe. The software break can follow either of two rules. In the shared-vector rule it uses the same vector as the maskable interrupt. In the separate-vector rule it uses its own base address, and that base can be offset by the operand byte fetched after the break opcode.

Top module: `intVecSelect`

## Requirements
- R1: After the block reset (`rstN` low), `vectorOut` is 0xFFFE and `sourceCode` is 2'b00.
- R2: A software break is recognised only when `instrReg` equals 0x00. It is reported with `sourceCode` 2'b11. Any non-zero opcode is never treated as a break.
- R3: Reset has the highest priority. When `resetReq` is high at a strobe, the block captures vector 0xFFFC and code 2'b10, even if a break, `nmiReq` or `irqReq` is also active.
- R4: A software break beats both `nmiReq` and `irqReq`. When it coincides with either of them, the captured code is 2'b11.
- R5: Vector 0xFFFA with code 2'b01 is captured only when `nmiReq` and `irqReq` are both high and neither reset nor break is active. A strobe with `nmiReq` high on its own, and no other accepted source, leaves the outputs unchanged.
- R6: When only the maskable request is present (`irqReq` high, `irqMask` low), the block captures vector 0xFFFE and code 2'b00.
- R7: While `irqMask` is high, a lone maskable request is not accepted and a strobe leaves the outputs unchanged. `irqMask` does not gate reset, break, or the R5 non-maskable selection.
- R8: With `sepBreakMode` low, a break captures vector 0xFFFE, the maskable-interrupt vector, with code 2'b11.
- R9: With `sepBreakMode` high and `breakOffsetEn` low, a break captures the vector BRK_BASE, which defaults to 0xFFE0. `breakOperand` is ignored.
- R10: With `sepBreakMode` and `breakOffsetEn` both high, a break captures BRK_BASE plus the zero-extended `breakOperand`, taken modulo 2^16.
- R11: The outputs change only on the clock edge where `vecStrobe` is high. They take the new value in the cycle after that edge and stay stable whenever `vecStrobe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| resetReq | input | 1 | Processor reset request |
| nmiReq | input | 1 | Non-maskable request, sampled level |
| irqReq | input | 1 | Maskable request, sampled level |
| irqMask | input | 1 | Interrupt-disable; high ignores a lone maskable request |
| instrReg | input | 8 | Current instruction register contents |
| breakOperand | input | 8 | Byte fetched after the break opcode |
| sepBreakMode | input | 1 | 1 = break gets its own vector, 0 = shares the maskable vector |
| breakOffsetEn | input | 1 | 1 = add breakOperand to the break base |
| vecStrobe | input | 1 | Vector request from the core, one cycle |
| vectorOut | output | 16 | Captured service-routine vector |
| sourceCode | output | 2 | Captured source: 00 maskable, 01 non-maskable, 10 reset, 11 break |

## Verification
The assertions check the following on every cycle: the priority outcomes at each strobe (reset over break, break over the non-maskable pairing, the shared-vector break address), the holding of outputs between strobes and under a masked lone request, and that at most one grant line is active. Some behaviours can only be shown by the bench's scenarios. These are the exact separate-vector addresses with and without the offset, including wrap-around past 0xFFFF, the reset state, and the fact that a lone non-maskable request and non-zero opcodes leave the outputs alone.

// File: rtl/intVecPkg.sv
package intVecPkg;

  typedef enum logic [1:0] {
    SRC_IRQ = 2'b00,
    SRC_NMI = 2'b01,
    SRC_RST = 2'b10,
    SRC_BRK = 2'b11
  } srcSel_t;

  typedef struct packed {
    logic    load;
    srcSel_t src;
  } vecCtrl_t;

  localparam int NUM_SRC = 4;

endpackage

// File: rtl/intVecCtrl.sv
module intVecCtrl
  import intVecPkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            resetReq,
  input  logic            nmiReq,
  input  logic            irqReq,
  input  logic            irqMask,
  input  logic [OP_W-1:0] instrReg,
  input  logic            vecStrobe,
  output vecCtrl_t        ctrl
);

  localparam logic [OP_W-1:0] BRK_OPCODE = '0;

  logic                 isBreak;
  logic                 nmiPair;
  logic                 irqLive;
  logic [NUM_SRC-1:0]   grant;

  assign isBreak = (instrReg == BRK_OPCODE);
  assign nmiPair = nmiReq & irqReq;
  assign irqLive = irqReq & ~irqMask;

  // grant[3]=reset, [2]=break, [1]=nmi pairing, [0]=maskable
  always_comb begin
    grant    = '0;
    grant[3] = resetReq;
    grant[2] = ~resetReq & isBreak;
    grant[1] = ~resetReq & ~isBreak & nmiPair;
    grant[0] = ~resetReq & ~isBreak & ~nmiPair & irqLive;
  end

  always_comb begin
    ctrl.load = vecStrobe & (|grant);
    unique casez (grant)
      4'b1???: ctrl.src = SRC_RST;
      4'b01??: ctrl.src = SRC_BRK;
      4'b001?: ctrl.src = SRC_NMI;
      default: ctrl.src = SRC_IRQ;
    endcase
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R3

  AST_OPCODE_BREAK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.src == SRC_BRK) |-> (instrReg == BRK_OPCODE)); // R2

endmodule

// File: rtl/intVecPath.sv
module intVecPath
  import intVecPkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              OP_W     = 8,
  parameter logic [ADDR_W-1:0] NMI_VEC  = 16'hFFFA,
  parameter logic [ADDR_W-1:0] RST_VEC  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] IRQ_VEC  = 16'hFFFE,
  parameter logic [ADDR_W-1:0] BRK_BASE = 16'hFFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  vecCtrl_t          ctrl,
  input  logic              sepBreakMode,
  input  logic              breakOffsetEn,
  input  logic [OP_W-1:0]   breakOperand,
  output logic [ADDR_W-1:0] vectorOut,
  output logic [1:0]        sourceCode
);

  localparam int PAD_W = ADDR_W - OP_W;

  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] breakVec;
  logic [ADDR_W-1:0] nextVec;
  logic [ADDR_W-1:0] vecQ;
  srcSel_t           srcQ;

  generate
    if (PAD_W > 0) begin : g_pad
      assign offsetExt = {{PAD_W{1'b0}}, breakOperand};
    end else begin : g_trunc
      assign offsetExt = breakOperand[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!sepBreakMode)      breakVec = IRQ_VEC;
    else if (breakOffsetEn) breakVec = BRK_BASE + offsetExt;
    else                    breakVec = BRK_BASE;
  end

  always_comb begin
    unique case (ctrl.src)
      SRC_RST: nextVec = RST_VEC;
      SRC_BRK: nextVec = breakVec;
      SRC_NMI: nextVec = NMI_VEC;
      default: nextVec = IRQ_VEC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ <= IRQ_VEC;
      srcQ <= SRC_IRQ;
    end else if (ctrl.load) begin
      vecQ <= nextVec;
      srcQ <= ctrl.src;
    end
  end

  assign vectorOut  = vecQ;
  assign sourceCode = srcQ;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(vecQ) && $stable(srcQ))); // R11

  AST_SEP_NOOFS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.src == SRC_BRK && sepBreakMode && !breakOffsetEn)
      |=> (vecQ == BRK_BASE)); // R9

endmodule

// File: rtl/intVecSelect.sv
module intVecSelect
  import intVecPkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              OP_W     = 8,
  parameter logic [ADDR_W-1:0] NMI_VEC  = 16'hFFFA,
  parameter logic [ADDR_W-1:0] RST_VEC  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] IRQ_VEC  = 16'hFFFE,
  parameter logic [ADDR_W-1:0] BRK_BASE = 16'hFFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              nmiReq,
  input  logic              irqReq,
  input  logic              irqMask,
  input  logic [OP_W-1:0]   instrReg,
  input  logic [OP_W-1:0]   breakOperand,
  input  logic              sepBreakMode,
  input  logic              breakOffsetEn,
  input  logic              vecStrobe,
  output logic [ADDR_W-1:0] vectorOut,
  output logic [1:0]        sourceCode
);

  vecCtrl_t ctrl;

  intVecCtrl #(.OP_W(OP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .resetReq  (resetReq),
    .nmiReq    (nmiReq),
    .irqReq    (irqReq),
    .irqMask   (irqMask),
    .instrReg  (instrReg),
    .vecStrobe (vecStrobe),
    .ctrl      (ctrl)
  );

  intVecPath #(
    .ADDR_W  (ADDR_W),
    .OP_W    (OP_W),
    .NMI_VEC (NMI_VEC),
    .RST_VEC (RST_VEC),
    .IRQ_VEC (IRQ_VEC),
    .BRK_BASE(BRK_BASE)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .sepBreakMode (sepBreakMode),
    .breakOffsetEn(breakOffsetEn),
    .breakOperand (breakOperand),
    .vectorOut    (vectorOut),
    .sourceCode   (sourceCode)
  );

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (vecStrobe && resetReq) |=> (vectorOut == RST_VEC && sourceCode == 2'b10)); // R3

  AST_BREAK_OVER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (vecStrobe && !resetReq && instrReg == '0) |=> (sourceCode == 2'b11)); // R4

  AST_SHARED_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (vecStrobe && !resetReq && instrReg == '0 && !sepBreakMode)
      |=> (vectorOut == IRQ_VEC)); // R8

  AST_NMI_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (vecStrobe && !resetReq && instrReg != '0 && nmiReq && irqReq)
      |=> (vectorOut == NMI_VEC && sourceCode == 2'b01)); // R5

  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (vecStrobe && irqMask && !resetReq && instrReg != '0 && !nmiReq)
      |=> ($stable(vectorOut) && $stable(sourceCode))); // R7

endmodule

// File: tb/intVecSelect_bench.sv
module intVecSelect_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 1'b0, nmiReq = 1'b0, irqReq = 1'b0, irqMask = 1'b0;
  logic [7:0]  instrReg = 8'hEA, breakOperand = 8'h00;
  logic        sepBreakMode = 1'b0, breakOffsetEn = 1'b0, vecStrobe = 1'b0;
  logic [15:0] vectorOut;
  logic [1:0]  sourceCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  intVecSelect u_intVecSelect (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiReq(nmiReq),
    .irqReq(irqReq), .irqMask(irqMask), .instrReg(instrReg),
    .breakOperand(breakOperand), .sepBreakMode(sepBreakMode),
    .breakOffsetEn(breakOffsetEn), .vecStrobe(vecStrobe),
    .vectorOut(vectorOut), .sourceCode(sourceCode)
  );

  task automatic chk(input string tag, input logic [15:0] expVec, input logic [1:0] expCode);
    checks++;
    if (vectorOut !== expVec || sourceCode !== expCode) begin
      fails++;
      $display("FAIL %s: vector=%h code=%b expected vector=%h code=%b",
               tag, vectorOut, sourceCode, expVec, expCode);
    end
  endtask

  // drive inputs at a falling edge, strobe for one cycle, outputs settle after the rising edge
  task automatic apply(input logic rst, input logic nmi, input logic irq, input logic msk,
                       input logic [7:0] ir, input logic [7:0] op,
                       input logic sep, input logic ofs);
    @(negedge clk);
    resetReq = rst; nmiReq = nmi; irqReq = irq; irqMask = msk;
    instrReg = ir; breakOperand = op; sepBreakMode = sep; breakOffsetEn = ofs;
    vecStrobe = 1'b1;
    @(negedge clk);
    vecStrobe = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 reset state", 16'hFFFE, 2'b00);
  endtask

  task automatic testMaskable();
    apply(0, 0, 1, 0, 8'hA9, 8'h00, 0, 0);
    chk("R6 lone maskable", 16'hFFFE, 2'b00);
  endtask

  task automatic testResetPriority();
    apply(1, 1, 1, 0, 8'h00, 8'h33, 1, 1);
    chk("R3 reset beats all", 16'hFFFC, 2'b10);
  endtask

  task automatic testNmi();
    apply(0, 1, 1, 0, 8'h4C, 8'h00, 1, 0);
    chk("R5 nmi with irq", 16'hFFFA, 2'b01);
    apply(1, 0, 0, 0, 8'h4C, 8'h00, 0, 0);
    apply(0, 1, 0, 0, 8'h4C, 8'h00, 0, 0);
    chk("R5 lone nmi holds", 16'hFFFC, 2'b10);
    apply(0, 1, 1, 1, 8'h4C, 8'h00, 0, 0);
    chk("R7 mask does not gate nmi", 16'hFFFA, 2'b01);
  endtask

  task automatic testMask();
    apply(1, 0, 0, 0, 8'h4C, 8'h00, 0, 0);
    apply(0, 0, 1, 1, 8'h4C, 8'h00, 0, 0);
    chk("R7 masked irq ignored", 16'hFFFC, 2'b10);
    apply(0, 0, 1, 1, 8'h00, 8'h00, 1, 0);
    chk("R7 mask does not gate break", 16'hFFE0, 2'b11);
  endtask

  task automatic testBreak();
    apply(0, 1, 1, 0, 8'h00, 8'h00, 0, 0);
    chk("R8 shared break beats nmi", 16'hFFFE, 2'b11);
    apply(0, 0, 1, 0, 8'h01, 8'h00, 1, 0);
    chk("R2 nonzero opcode no break", 16'hFFFE, 2'b00);
    apply(0, 1, 1, 0, 8'h00, 8'h55, 1, 0);
    chk("R9 separate no offset", 16'hFFE0, 2'b11);
    apply(0, 0, 1, 0, 8'h00, 8'h10, 1, 1);
    chk("R10 offset 0x10", 16'hFFF0, 2'b11);
    apply(0, 0, 0, 0, 8'h00, 8'h40, 1, 1);
    chk("R10 offset wraps", 16'h0020, 2'b11);
    apply(0, 1, 0, 0, 8'h00, 8'h02, 1, 1);
    chk("R4 break beats lone nmi", 16'hFFE2, 2'b11);
  endtask

  task automatic testHold();
    apply(0, 1, 1, 0, 8'h60, 8'h00, 0, 0);
    @(negedge clk);
    resetReq = 1; instrReg = 8'h00; nmiReq = 0;
    repeat (3) @(negedge clk);
    chk("R11 no strobe holds", 16'hFFFA, 2'b01);
    vecStrobe = 1'b1;
    #5;
    chk("R11 no change before edge", 16'hFFFA, 2'b01);
    @(negedge clk);
    vecStrobe = 1'b0;
    chk("R11 change after edge", 16'hFFFC, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMaskable();
    testResetPriority();
    testNmi();
    testMask();
    testBreak();
    testHold();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: run hung");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule